// File: doc/BRIEF.md
# Staged Coefficient Memory Gateway

The block sits behind a byte-wide register port, such as the back end of a two-wire serial slave, and gives a host indirect access to a small memory of 24-bit filter coefficients. The host writes a word address and up to five coefficients, each as three bytes, into staging registers. It then sets a trigger bit that asks for either a single-word write or a five-word biquad set written to consecutive addresses. On the trigger, the block copies the staging contents and the address into a private shadow. The commit waits for the next audio sample strobe and then runs as a burst of one memory write per clock. The filter engine, which reads the memory through its own port, therefore never sees a half-updated set.

Reads take the same indirect path. The host writes the address and sets the read trigger. The word then appears in a read-result register made of three bytes. That register is separate from the staging bytes, so a read never damages a write that is still waiting for its strobe.

Top module: `coef_gate`

## Requirements
- R1: After reset the address register, all staging bytes, the read result, the control register and every memory word read as zero, and the filter port returns zero.
- R2: Register 0x27 holds the 6-bit word address and reads back with bits 7:6 as zero. Coefficient k (k = 0..4) occupies registers 0x28+3k (bits 23:16), 0x29+3k (bits 15:8) and 0x2A+3k (bits 7:0). Coefficients 1..4 read back as written. Reads of 0x28..0x2A return the read result instead. Register 0x37 is control: bit 0 writes one word, bit 1 writes a set, bit 2 reads a word, and bit 3 is busy (read-only).
- R3: A control write with bit 2 set loads the word at the current address into the read result. The value is readable on the second clock edge after the control write. Bit 2 reads as 1 until the load is done and as 0 afterwards.
- R4: A single-word write stores only staged coefficient 0, at the snapshot address, and leaves the neighbouring words unchanged.
- R5: A set write stores coefficients 0..4 at the snapshot address plus 0..4, modulo 64, so a base of 62 writes words 62, 63, 0, 1, 2.
- R6: A commit starts no memory write until a sample strobe is seen. Writes occur on the 1st to 5th clock edges after the edge that sampled the strobe (only the 1st edge for a single-word write). Busy reads as 0 once the last write is done.
- R7: The trigger bit of a pending or running write and the busy bit read as 1 from the trigger until the commit completes. While a write is pending or running, write-trigger bits in a control write are ignored.
- R8: Staging or address writes made after a write trigger do not change the data or the addresses that this commit stores.
- R9: A read served while a write waits for its strobe returns the memory contents from before that write.
- R10: When bits 0 and 1 are both set in one control write, a set write is performed.
- R11: The filter port returns, one clock edge later, the memory word at the filter address it sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address for reads and writes |
| regWData | input | 8 | Register write data |
| regRData | output | 8 | Register read data, combinational from regAddr |
| sampleStrobe | input | 1 | Audio sample strobe; a commit starts after it |
| filtAddr | input | 6 | Filter engine word address |
| filtData | output | 24 | Filter engine read data, registered |

## Verification
The bench builds the block with its default parameters: a 6-bit address, 24-bit words and five words to a set. With these values a base of 62 wraps within one burst, and the five busy cycles after a strobe can be counted edge by edge. Three cases are driven against the bench's own model of the memory: a read while a commit waits for its strobe, a staging overwrite made after a trigger, and an ignored single-word trigger.

// File: rtl/coef_gate_pkg.sv
package coef_gate_pkg;

  // Width of the burst index carried between control and datapath; sets up to 8 words.
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PEND,
    PH_BURST
  } phase_t;

  // Strobes the control hands to the datapath each cycle.
  typedef struct packed {
    logic             snap;     // copy staging and address into the shadow
    logic             readNow;  // load the read result from memory
    logic             wrEn;     // write one shadow word to memory
    logic [IDX_W-1:0] wrIdx;    // which shadow word / address offset
  } strobe_t;

endpackage

// File: rtl/coef_ram.sv
module coef_ram #(
  parameter int ADDR_W = 6,
  parameter int COEF_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [COEF_W-1:0] wData,
  input  logic [ADDR_W-1:0] hAddr,
  output logic [COEF_W-1:0] hData,
  input  logic [ADDR_W-1:0] fAddr,
  output logic [COEF_W-1:0] fData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [COEF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wAddr] <= wData;
    end
  end

  // The filter read is registered, so it sees the word as it stood before a write on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fData <= '0;
    else       fData <= mem[fAddr];
  end

  assign hData = mem[hAddr];

endmodule

// File: rtl/coef_ctrl.sv
module coef_ctrl
  import coef_gate_pkg::*;
#(
  parameter int         SET_LEN   = 5,
  parameter logic [7:0] CTRL_ADDR = 8'h37
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic [2:0] ctrlBits,
  input  logic       sampleStrobe,
  output strobe_t    st,
  output logic [7:0] ctrlRd
);
  localparam logic [IDX_W-1:0] LAST_SET = IDX_W'(SET_LEN - 1);

  phase_t           phase;
  logic             isSet;
  logic [IDX_W-1:0] idx;
  logic             readPend;
  logic             ctrlHit;
  logic             wrReq;
  logic             lastIdx;
  logic             busy;

  assign ctrlHit = regWe && (regAddr == CTRL_ADDR);
  assign wrReq   = ctrlHit && (ctrlBits[0] || ctrlBits[1]);
  assign lastIdx = isSet ? (idx == LAST_SET) : (idx == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      isSet <= 1'b0;
      idx   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (wrReq) begin
            isSet <= ctrlBits[1];   // set write wins when both bits are given
            phase <= PH_PEND;
          end
        end
        PH_PEND: begin
          if (sampleStrobe) begin
            idx   <= '0;
            phase <= PH_BURST;
          end
        end
        PH_BURST: begin
          if (lastIdx) begin
            idx   <= '0;
            phase <= PH_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPend <= 1'b0;
    end else if (ctrlHit && ctrlBits[2]) begin
      readPend <= 1'b1;
    end else if (st.readNow) begin
      readPend <= 1'b0;
    end
  end

  assign busy = (phase != PH_IDLE) || readPend;

  always_comb begin
    st.snap    = (phase == PH_IDLE) && wrReq;
    st.readNow = readPend && (phase != PH_BURST);
    st.wrEn    = (phase == PH_BURST);
    st.wrIdx   = idx;
  end

  assign ctrlRd = {4'b0000, busy, readPend,
                   (phase != PH_IDLE) && isSet,
                   (phase != PH_IDLE) && !isSet};

  // R6: the first write of a commit follows a sampled strobe
  assert_start_on_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && idx == '0) |-> $past(sampleStrobe));

  // R5: burst writes run on consecutive cycles with a rising index
  assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && idx != '0) |-> ($past(st.wrEn) && idx == $past(idx) + 1'b1));

  // R4: a single-word commit never goes past index zero
  assert_single_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrEn && !isSet) |-> (idx == '0));

  // R7: a write trigger while busy leaves the running kind unchanged
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && wrReq) |=> $stable(isSet));

  // R7: busy is shown whenever memory is being written
  assert_busy_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |-> ctrlRd[3]);

endmodule

// File: rtl/coef_datapath.sv
module coef_datapath
  import coef_gate_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         COEF_W   = 24,
  parameter int         SET_LEN  = 5,
  parameter logic [7:0] REG_BASE = 8'h27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [7:0]        regAddr,
  input  logic [7:0]        regWData,
  output logic [7:0]        regRData,
  input  logic [7:0]        ctrlRd,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] filtAddr,
  output logic [COEF_W-1:0] filtData
);
  localparam int BYTES    = COEF_W / 8;
  localparam int CTRL_OFS = 1 + SET_LEN * BYTES;

  logic [7:0]        regOfs;
  logic [ADDR_W-1:0] addrReg;
  logic [COEF_W-1:0] stage   [SET_LEN];
  logic [COEF_W-1:0] shCoef  [SET_LEN];
  logic [ADDR_W-1:0] shBase;
  logic [COEF_W-1:0] readback;
  logic [COEF_W-1:0] hostData;
  logic [ADDR_W-1:0] wrAddr;

  assign regOfs = regAddr - REG_BASE;

  // Host-facing staging: address and coefficient bytes, top byte at the lowest register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      for (int k = 0; k < SET_LEN; k++) stage[k] <= '0;
    end else if (regWe) begin
      if (regOfs == 8'd0) addrReg <= regWData[ADDR_W-1:0];
      for (int k = 0; k < SET_LEN; k++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (regOfs == 8'(1 + k * BYTES + b))
            stage[k][(BYTES-1-b)*8 +: 8] <= regWData;
        end
      end
    end
  end

  // Shadow captured at the trigger; the burst only ever reads from here
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shBase <= '0;
      for (int k = 0; k < SET_LEN; k++) shCoef[k] <= '0;
    end else if (st.snap) begin
      shBase <= addrReg;
      for (int k = 0; k < SET_LEN; k++) shCoef[k] <= stage[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           readback <= '0;
    else if (st.readNow) readback <= hostData;
  end

  assign wrAddr = shBase + ADDR_W'(st.wrIdx);

  coef_ram #(
    .ADDR_W (ADDR_W),
    .COEF_W (COEF_W)
  ) u_ram (
    .clk   (clk),
    .rstN  (rstN),
    .we    (st.wrEn),
    .wAddr (wrAddr),
    .wData (shCoef[st.wrIdx]),
    .hAddr (addrReg),
    .hData (hostData),
    .fAddr (filtAddr),
    .fData (filtData)
  );

  always_comb begin
    regRData = 8'h00;
    if (regOfs == 8'd0) regRData = 8'(addrReg);
    for (int k = 0; k < SET_LEN; k++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (regOfs == 8'(1 + k * BYTES + b))
          regRData = (k == 0) ? readback[(BYTES-1-b)*8 +: 8]
                              : stage[k][(BYTES-1-b)*8 +: 8];
      end
    end
    if (regOfs == 8'(CTRL_OFS)) regRData = ctrlRd;
  end

  // R8: the shadow holds still for the whole of a burst
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |-> ($stable(shBase) && $stable(shCoef[0]) && $stable(shCoef[SET_LEN-1])));

  // R9: a read load never coincides with a memory write
  assert_read_apart_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.readNow |-> !st.wrEn);

endmodule

// File: rtl/coef_gate.sv
module coef_gate
  import coef_gate_pkg::*;
#(
  parameter int         ADDR_W   = 6,
  parameter int         COEF_W   = 24,
  parameter int         SET_LEN  = 5,
  parameter logic [7:0] REG_BASE = 8'h27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [7:0]        regAddr,
  input  logic [7:0]        regWData,
  output logic [7:0]        regRData,
  input  logic              sampleStrobe,
  input  logic [ADDR_W-1:0] filtAddr,
  output logic [COEF_W-1:0] filtData
);
  localparam int         BYTES     = COEF_W / 8;
  localparam logic [7:0] CTRL_ADDR = REG_BASE + 8'(1 + SET_LEN * BYTES);

  strobe_t    st;
  logic [7:0] ctrlRd;

  coef_ctrl #(
    .SET_LEN   (SET_LEN),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .regWe        (regWe),
    .regAddr      (regAddr),
    .ctrlBits     (regWData[2:0]),
    .sampleStrobe (sampleStrobe),
    .st           (st),
    .ctrlRd       (ctrlRd)
  );

  coef_datapath #(
    .ADDR_W   (ADDR_W),
    .COEF_W   (COEF_W),
    .SET_LEN  (SET_LEN),
    .REG_BASE (REG_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWData (regWData),
    .regRData (regRData),
    .ctrlRd   (ctrlRd),
    .st       (st),
    .filtAddr (filtAddr),
    .filtData (filtData)
  );

endmodule

// File: tb/test_coef_gate.sv
`timescale 1ns/1ps
module test_coef_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [7:0]  regWData = 8'h00;
  logic [7:0]  regRData;
  logic        sampleStrobe = 1'b0;
  logic [5:0]  filtAddr = 6'd0;
  logic [23:0] filtData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [23:0] model [64];
  logic [23:0] expQ [$];
  string       reqQ [$];
  logic [23:0] actQ [$];

  always #2.5 clk = ~clk;  // 200 MHz

  coef_gate i_coef_gate (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .sampleStrobe(sampleStrobe),
    .filtAddr(filtAddr), .filtData(filtData)
  );

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Monitor: pops expected words as the design's read results arrive
  initial begin
    forever begin
      @(negedge clk);
      while (actQ.size() > 0 && expQ.size() > 0) begin
        logic [23:0] a, e;
        string r;
        a = actQ.pop_front();
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(r, a, e);
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRData;
  endtask

  task automatic stageWord(input int k, input logic [23:0] v);
    regWrite(8'(8'h28 + 3*k), v[23:16]);
    regWrite(8'(8'h29 + 3*k), v[15:8]);
    regWrite(8'(8'h2A + 3*k), v[7:0]);
  endtask

  // Driver: push the expected word, then fetch the word through the read trigger
  task automatic expectWord(input string req, input logic [5:0] addr, input logic [23:0] v);
    logic [7:0] b2, b1, b0;
    expQ.push_back(v);
    reqQ.push_back(req);
    regWrite(8'h27, 8'(addr));
    regWrite(8'h37, 8'h04);
    @(negedge clk);
    regRead(8'h28, b2);
    regRead(8'h29, b1);
    regRead(8'h2A, b0);
    actQ.push_back({b2, b1, b0});
  endtask

  task automatic pulseStrobe();
    @(negedge clk); sampleStrobe = 1'b1;
    @(negedge clk); sampleStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    logic [7:0] c;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      regRead(8'h37, c);
      if (!c[3]) break;
    end
  endtask

  initial begin
    logic [7:0] c;
    logic [23:0] v [5];
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    regRead(8'h27, c); check("R1", 24'(c), 24'h0);
    regRead(8'h2B, c); check("R1", 24'(c), 24'h0);
    regRead(8'h37, c); check("R1", 24'(c), 24'h0);
    check("R1", filtData, 24'h0);
    expectWord("R1", 6'd5, 24'h0);

    // R2: register map and readback
    regWrite(8'h27, 8'hFF);
    regRead(8'h27, c); check("R2", 24'(c), 24'h3F);
    stageWord(3, 24'hA1B2C3);
    regRead(8'h31, c); check("R2", 24'(c), 24'hA1);
    regRead(8'h32, c); check("R2", 24'(c), 24'hB2);
    regRead(8'h33, c); check("R2", 24'(c), 24'hC3);

    // R4: single-word write stores only coefficient 0
    stageWord(0, 24'h123456);
    stageWord(1, 24'h777777);
    regWrite(8'h27, 8'd10);
    regWrite(8'h37, 8'h01);
    regRead(8'h37, c); check("R7", 24'(c), 24'h09);
    pulseStrobe();
    waitIdle();
    regRead(8'h37, c); check("R7", 24'(c), 24'h00);
    model[10] = 24'h123456;
    expectWord("R4", 6'd10, model[10]);
    expectWord("R4", 6'd11, model[11]);
    // R3: the read trigger bit has cleared
    regRead(8'h37, c); check("R3", 24'(c & 8'h04), 24'h0);

    // R5/R6: set write at base 20 with edge-exact busy window
    v[0] = 24'h100001; v[1] = 24'h200002; v[2] = 24'h300003; v[3] = 24'h400004; v[4] = 24'h500005;
    for (int k = 0; k < 5; k++) stageWord(k, v[k]);
    regWrite(8'h27, 8'd20);
    regWrite(8'h37, 8'h02);
    repeat (4) @(negedge clk);
    regRead(8'h37, c); check("R6", 24'(c), 24'h0A);   // still waiting for the strobe
    filtAddr = 6'd22;
    @(negedge clk); check("R6", filtData, 24'h0);
    @(negedge clk); sampleStrobe = 1'b1;
    @(negedge clk); sampleStrobe = 1'b0;
    regRead(8'h37, c); check("R6", 24'(c), 24'h0A);
    repeat (4) @(negedge clk);
    regRead(8'h37, c); check("R6", 24'(c & 8'h08), 24'h08);
    @(negedge clk);
    regRead(8'h37, c); check("R6", 24'(c), 24'h00);
    for (int k = 0; k < 5; k++) model[20 + k] = v[k];
    @(negedge clk); check("R11", filtData, v[2]);
    filtAddr = 6'd24;
    @(negedge clk); check("R11", filtData, v[4]);
    for (int k = 0; k < 5; k++) expectWord("R5", 6'(20 + k), model[20 + k]);
    expectWord("R5", 6'd25, model[25]);

    // R5: wrap of the address past the top of memory
    for (int k = 0; k < 5; k++) begin v[k] = 24'(32'hC0000 + k); stageWord(k, v[k]); end
    regWrite(8'h27, 8'd62);
    regWrite(8'h37, 8'h02);
    pulseStrobe();
    waitIdle();
    for (int k = 0; k < 5; k++) model[(62 + k) % 64] = v[k];
    expectWord("R5", 6'd62, model[62]);
    expectWord("R5", 6'd63, model[63]);
    expectWord("R5", 6'd0,  model[0]);
    expectWord("R5", 6'd2,  model[2]);
    expectWord("R5", 6'd3,  model[3]);

    // R8/R9/R7: pending set write at 40, disturbed staging, read while pending
    for (int k = 0; k < 5; k++) begin v[k] = 24'(32'hE00000 + 16 * k); stageWord(k, v[k]); end
    regWrite(8'h27, 8'd40);
    regWrite(8'h37, 8'h02);
    stageWord(2, 24'hDEAD01);
    expectWord("R9", 6'd40, model[40]);
    regWrite(8'h27, 8'd50);
    regWrite(8'h37, 8'h01);                           // ignored while busy
    regRead(8'h37, c); check("R7", 24'(c), 24'h0A);
    pulseStrobe();
    waitIdle();
    for (int k = 0; k < 5; k++) model[40 + k] = v[k];
    expectWord("R8", 6'd42, model[42]);
    expectWord("R5", 6'd40, model[40]);
    expectWord("R5", 6'd44, model[44]);
    pulseStrobe();
    repeat (8) @(negedge clk);
    expectWord("R7", 6'd50, model[50]);

    // R10: both write bits select a set write
    for (int k = 0; k < 5; k++) begin v[k] = 24'(32'h0A0B00 + k); stageWord(k, v[k]); end
    regWrite(8'h27, 8'd30);
    regWrite(8'h37, 8'h03);
    regRead(8'h37, c); check("R10", 24'(c), 24'h0A);
    pulseStrobe();
    waitIdle();
    for (int k = 0; k < 5; k++) model[30 + k] = v[k];
    expectWord("R10", 6'd31, model[31]);
    expectWord("R10", 6'd34, model[34]);

    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; failures++;
      $display("FAIL R3 actual=%0d expected=0 unmatched reads", expQ.size());
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL R7 actual=hung expected=finished watchdog");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule